// File: doc/BRIEF.md
# Variable-Rotation Circular Pattern Sequencer

This block drives the test inputs of a circuit under test from one circular register of width `W`. In the design under test, that register chains the primary inputs and the scan cells in series. Reset clears the register, and the all-zero word it leaves behind is the first seed. Every later seed is copied in parallel from `seed_i`. The surrounding feedback logic builds `seed_i` from the circuit's own responses, so no seed is stored anywhere. That includes the first seed of each new configuration, which comes from the response to the last pattern of the previous configuration.

After a seed is applied, the register rotates by one position per test cycle for a number of cycles chosen for that seed. The schedule is fixed at elaboration by three parameter tables, each with one entry per seed:
- the rotation the seed needs,
- the group the seed belongs to,
- the feedback configuration the seed uses.

All seeds in a group rotate for the largest need found in that group. When all seeds have been applied, the block raises `done_o` and freezes.

Top module: `rot_seq`

## Requirements
- R1: While `rst_n` is low, `pat_o` is all zeros, `mode_o` is 0, `done_o` is 0 and `cfg_o` shows configuration entry 0. The zero word is applied as seed 0 in the first cycle after release.
- R2: In a rotate cycle, `mode_o` is 1 and `pat_o` is the previous pattern rotated left by one: bit W-1 wraps into bit 0 and every other bit k moves to bit k+1.
- R3: When a seed's rotations are finished and seeds remain, the next cycle applies the value of `seed_i` sampled at that clock edge, with `mode_o` = 0. Loading takes exactly one cycle.
- R4: Seed k gets exactly R_k rotate cycles. R_k is the largest need among the seeds that share k's group, clamped to W-1.
- R5: A seed whose R_k is 0 is applied for a single cycle. The next cycle is then either the next load or the done state.
- R6: `done_o` rises in the cycle after the last pattern of the final seed. From then until reset, `pat_o`, `mode_o` and `cfg_o` hold and `done_o` stays 1.
- R7: `cfg_o` is the configuration entry of the seed being applied, and it does not change during that seed's rotations. In every table, entry k sits at bits [k*w +: w], where w is the entry width.
- R8: `seed_i` is sampled only on load edges. During rotate cycles and after done, its value has no effect on `pat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the register to the zero seed |
| seed_i | input | W | Seed from the feedback logic unit |
| pat_o | output | W | Pattern applied to the circuit under test |
| mode_o | output | 1 | 1 in a rotate cycle, 0 in a load cycle or after done |
| cfg_o | output | CFGW | Feedback configuration select for the current seed |
| done_o | output | 1 | Schedule complete |

## Verification
Every output is a register, so the result of any edge is visible one cycle later. A loaded seed appears in the cycle after the edge that sampled `seed_i`. Each rotation appears in the cycle after its edge. `done_o` rises one cycle after the final seed's last pattern. The bench drives `seed_i` and reads all outputs on falling edges. It advances its own expected state once per rising edge, so every comparison falls in the cycle where the new value is due. Random seeds change on every cycle, including rotate cycles and the cycles after done, so any sampling of `seed_i` outside a load edge shows up in `pat_o`.

// File: rtl/rot_seq.sv
`timescale 1ns/1ps
module rot_seq #(
  parameter int W     = 8,
  parameter int NSEED = 4,
  parameter int CNTW  = 4,
  parameter int GRPW  = 2,
  parameter int CFGW  = 2,
  parameter logic [NSEED*CNTW-1:0] NEED_TAB = {4'd0, 4'd9, 4'd1, 4'd3},
  parameter logic [NSEED*GRPW-1:0] GRP_TAB  = {2'd2, 2'd1, 2'd1, 2'd0},
  parameter logic [NSEED*CFGW-1:0] CFG_TAB  = {2'd1, 2'd1, 2'd0, 2'd0}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    seed_i,
  output logic [W-1:0]    pat_o,
  output logic            mode_o,
  output logic [CFGW-1:0] cfg_o,
  output logic            done_o
);
  localparam int IW = (NSEED > 1) ? $clog2(NSEED) : 1;

  function automatic logic [CNTW-1:0] grp_count(input int s);
    int m;
    m = 0;
    for (int j = 0; j < NSEED; j++)
      if (GRP_TAB[j*GRPW +: GRPW] == GRP_TAB[s*GRPW +: GRPW] &&
          int'(NEED_TAB[j*CNTW +: CNTW]) > m)
        m = int'(NEED_TAB[j*CNTW +: CNTW]);
    if (m > W - 1) m = W - 1;
    return CNTW'(m);
  endfunction

  logic [CNTW-1:0] rot_tab [NSEED];
  for (genvar g = 0; g < NSEED; g++) begin : g_rot
    assign rot_tab[g] = grp_count(g);
  end

  logic [IW-1:0]   idx;
  logic [IW-1:0]   nxt;
  logic [CNTW-1:0] cnt;
  logic            last;

  assign nxt   = idx + 1'b1;
  assign last  = (idx == IW'(NSEED - 1));
  assign cfg_o = CFG_TAB[idx*CFGW +: CFGW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_o  <= '0;
      idx    <= '0;
      cnt    <= rot_tab[0];
      mode_o <= 1'b0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (cnt != '0) begin
        pat_o  <= {pat_o[W-2:0], pat_o[W-1]};
        cnt    <= cnt - 1'b1;
        mode_o <= 1'b1;
      end else if (last) begin
        done_o <= 1'b1;
        mode_o <= 1'b0;
      end else begin
        idx    <= nxt;
        pat_o  <= seed_i;
        cnt    <= rot_tab[nxt];
        mode_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rot_seq_chk.sv
`timescale 1ns/1ps
module rot_seq_chk #(
  parameter int W    = 8,
  parameter int CFGW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    seed_i,
  input logic [W-1:0]    pat_o,
  input logic            mode_o,
  input logic [CFGW-1:0] cfg_o,
  input logic            done_o
);
  int run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else        run <= mode_o ? run + 1 : 0;

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> (pat_o == '0 && !done_o && !mode_o));

  assert_rotate_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o |-> (pat_o == {$past(pat_o[W-2:0]), $past(pat_o[W-1])}));

  assert_load_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o && !done_o && $past(rst_n)) |-> (pat_o == $past(seed_i)));

  assert_rotate_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o |-> (run < W - 1));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(pat_o) && $stable(cfg_o) && !mode_o));

  assert_cfg_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o |-> $stable(cfg_o));
endmodule

bind rot_seq rot_seq_chk #(.W(W), .CFGW(CFGW)) chk_i (
  .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .pat_o(pat_o),
  .mode_o(mode_o), .cfg_o(cfg_o), .done_o(done_o));

// File: tb/rot_seq_tb.sv
`timescale 1ns/1ps
module rot_seq_tb_top;
  localparam int W = 8, NSEED = 4, CNTW = 4, GRPW = 2, CFGW = 2;
  localparam int NEED [NSEED] = '{3, 1, 9, 0};
  localparam int GRP  [NSEED] = '{0, 1, 1, 2};
  localparam int CFG  [NSEED] = '{0, 0, 1, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic [W-1:0] pat_o;
  logic mode_o, done_o;
  logic [CFGW-1:0] cfg_o;

  always #5 clk = ~clk;

  rot_seq dut_i (.clk(clk), .rst_n(rst_n), .seed_i(seed_i), .pat_o(pat_o),
                 .mode_o(mode_o), .cfg_o(cfg_o), .done_o(done_o));

  int n_chk = 0, n_err = 0;

  function automatic int eff_rot(input int s);
    int best = 0;
    for (int g = 0; g < NSEED; g++)
      if (GRP[g] == GRP[s]) best = (NEED[g] > best) ? NEED[g] : best;
    return (best > W - 1) ? W - 1 : best;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  logic [W-1:0] e_pat;
  int e_idx, e_left;
  logic e_mode, e_done;

  task automatic run_sched(input int ncyc, input int kind);
    logic [W-1:0] walk;
    walk = 8'h01;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset pat", 32'(pat_o), 0);
    chk("R1 reset done", 32'(done_o), 0);
    chk("R1 reset mode", 32'(mode_o), 0);
    chk("R1 reset cfg", 32'(cfg_o), 32'(CFG[0]));
    rst_n = 1'b1;
    e_pat = '0; e_idx = 0; e_left = eff_rot(0); e_mode = 0; e_done = 0;
    for (int c = 0; c < ncyc; c++) begin
      chk(e_done ? "R6 held pat" : (e_mode ? "R2 R8 rotated pat" : "R3 loaded pat"),
          32'(pat_o), 32'(e_pat));
      chk(eff_rot(e_idx) == 0 ? "R5 R4 mode" : "R4 mode", 32'(mode_o), 32'(e_mode));
      chk("R7 cfg", 32'(cfg_o), 32'(CFG[e_idx]));
      chk("R6 done", 32'(done_o), 32'(e_done));
      case (kind)
        0: seed_i = W'($urandom);
        1: seed_i = '1;
        default: begin seed_i = walk; walk = {walk[W-2:0], walk[W-1]} ^ 8'h80; end
      endcase
      @(posedge clk);
      if (!e_done) begin
        if (e_left != 0) begin
          e_pat = {e_pat[W-2:0], e_pat[W-1]}; e_left--; e_mode = 1;
        end else if (e_idx == NSEED - 1) begin
          e_done = 1; e_mode = 0;
        end else begin
          e_idx++; e_pat = seed_i; e_left = eff_rot(e_idx); e_mode = 0;
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    run_sched(30, 0);
    run_sched(28, 1);
    run_sched(28, 2);
    run_sched(12, 0);
    run_sched(35, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule